// File: doc/BRIEF.md
# Clock-Enable Power State Controller

This block tracks the low-power state of a synchronous DRAM device from its clock-enable input. Each clock it compares the clock-enable level seen on the previous edge with the level on the current edge, and it decodes the chip-select, row-strobe, column-strobe and write-enable pins. From these it decides whether the device enters or leaves power-down, self-refresh or clock suspend. A bank tracker elsewhere supplies a flag that says all banks are idle. The two low-power states may only be entered while that flag is set.

On a self-refresh exit the controller holds a recovery state for a fixed number of cycles before it returns to normal operation. It keeps a refresh-busy flag raised for the whole of self-refresh and recovery. Any command that breaks the entry or exit rules produces a one-cycle illegal-command pulse. All outputs are registered and change on the clock edge that samples the stimulus.

Top module: `cke_power_ctrl`

## Requirements
- R1: While reset is low and on the first cycle after it, the state output reads RUN (code 0), refresh-busy is 0 and illegal is 0. The previous clock-enable sample resets to high.
- R2: In RUN with banks idle, a clock-enable fall (previous high, current low) with the refresh command (select 0, row strobe 0, column strobe 0, write enable 1) moves the state to SREF (code 2) on that edge and raises refresh-busy.
- R3: In RUN with banks idle, a clock-enable fall with a deselect (select 1) or a no-operation (select 0, both strobes and write enable 1) moves the state to PDOWN (code 1).
- R4: In RUN with banks not idle, a clock-enable fall moves the state to SUSPEND (code 4) whatever the command, and no low-power state is entered.
- R5: In RUN with banks idle, a clock-enable fall with any command other than refresh, deselect or no-operation pulses illegal for one cycle and moves the state to SUSPEND.
- R6: In PDOWN, clock enable held low keeps PDOWN. A low-to-high clock-enable pair returns the state to RUN on that edge.
- R7: In SREF, clock enable held low keeps SREF. A low-to-high pair with deselect or no-operation moves the state to RECOVER (code 3). RECOVER lasts exactly RC_CYCLES cycles and then the state is RUN. Refresh-busy is 1 in SREF and RECOVER and 0 elsewhere.
- R8: In SREF, a low-to-high clock-enable pair with any other command pulses illegal for one cycle, and the state stays SREF.
- R9: In RECOVER, any command other than deselect or no-operation pulses illegal for one cycle, and the recovery count continues undisturbed.
- R10: In SUSPEND, clock enable low keeps SUSPEND. Clock enable high returns the state to RUN on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cke_i | input | 1 | Clock-enable level for this edge |
| cs_n_i | input | 1 | Chip select, active low |
| ras_n_i | input | 1 | Row strobe, active low |
| cas_n_i | input | 1 | Column strobe, active low |
| we_n_i | input | 1 | Write enable, active low |
| banks_idle_i | input | 1 | All banks idle, from the bank tracker |
| pstate_o | output | 3 | Power state: 0 RUN, 1 PDOWN, 2 SREF, 3 RECOVER, 4 SUSPEND |
| refresh_busy_o | output | 1 | Self-refresh or its recovery in progress |
| illegal_o | output | 1 | One-cycle pulse for a rule-breaking command |

## Verification
Two functions can meet on one edge. The first is the recovery countdown. The second is the illegal-command check on commands that arrive during recovery. The bench drives a read command in the middle of RECOVER. On that same edge it expects the illegal pulse, no change of state, and the normal return to RUN after exactly RC_CYCLES cycles. A second case puts a state transition and the illegal flag on one edge: a clock-enable fall with an activate command while banks are idle. On that edge both SUSPEND and the illegal pulse must appear together.

// File: rtl/cke_pwr_pkg.sv
`timescale 1ns/1ps
// Shared types for the clock-enable power state controller.
// Assumes a 3-bit state code that consumers decode by value.
package cke_pwr_pkg;

    typedef enum logic [2:0] {
        PS_RUN     = 3'd0,
        PS_PDOWN   = 3'd1,
        PS_SREF    = 3'd2,
        PS_RECOVER = 3'd3,
        PS_SUSPEND = 3'd4
    } pstate_e;

    // Command classes that the state machine needs to tell apart.
    typedef struct packed {
        logic desel;    // chip not selected
        logic nop;      // selected, no strobe active
        logic refresh;  // both strobes low, write enable high
    } cmd_class_t;

endpackage

// File: rtl/cke_edge_sampler.sv
`timescale 1ns/1ps
// Registers the clock-enable level so that each edge sees a
// previous/current pair. It derives fall, rise and hold-low events.
// Assumes cke_i is already synchronous to clk.
module cke_edge_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic cke_i,
    output logic cke_prev_o,
    output logic fall_o,
    output logic rise_o,
    output logic hold_low_o
);

    logic cke_q;

    // Keep the level seen on the previous edge; reset assumes it was high.
    always_ff @(posedge clk) begin
        if (!rst_n) cke_q <= 1'b1;
        else        cke_q <= cke_i;
    end

    // Classify the previous/current pair.
    always_comb begin
        cke_prev_o = cke_q;
        fall_o     = cke_q & ~cke_i;
        rise_o     = ~cke_q & cke_i;
        hold_low_o = ~cke_q & ~cke_i;
    end

endmodule

// File: rtl/cke_cmd_classifier.sv
`timescale 1ns/1ps
// Decodes the command pins into the classes used by the power FSM.
// Purely combinational. Assumes active-low pins.
module cke_cmd_classifier
    import cke_pwr_pkg::*;
(
    input  logic       cs_n_i,
    input  logic       ras_n_i,
    input  logic       cas_n_i,
    input  logic       we_n_i,
    output cmd_class_t cls_o
);

    // Map the pin pattern to at most one class.
    always_comb begin
        cls_o.desel   = cs_n_i;
        cls_o.nop     = ~cs_n_i & ras_n_i & cas_n_i & we_n_i;
        cls_o.refresh = ~cs_n_i & ~ras_n_i & ~cas_n_i & we_n_i;
    end

endmodule

// File: rtl/cke_sr_recovery_timer.sv
`timescale 1ns/1ps
// Counts the row-cycle recovery after a self-refresh exit.
// load_i starts a window of RC_CYCLES cycles. done_o is high on the
// last cycle of the window. Assumes RC_CYCLES >= 1.
module cke_sr_recovery_timer #(
    parameter int RC_CYCLES = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic en_i,
    output logic done_o
);

    localparam int CW = (RC_CYCLES > 1) ? $clog2(RC_CYCLES) : 1;
    localparam logic [CW-1:0] LOAD_VAL = CW'(RC_CYCLES - 1);

    generate
        if (RC_CYCLES == 1) begin : g_single
            // A one-cycle window needs no counter.
            assign done_o = 1'b1;
        end else begin : g_count
            logic [CW-1:0] cnt_q;

            // Load on exit, then count down to zero while enabled.
            always_ff @(posedge clk) begin
                if (!rst_n)                        cnt_q <= '0;
                else if (load_i)                   cnt_q <= LOAD_VAL;
                else if (en_i && cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
            end

            assign done_o = (cnt_q == '0);
        end
    endgenerate

endmodule

// File: rtl/cke_power_ctrl.sv
`timescale 1ns/1ps
// Clock-enable power state controller (top).
// From the previous/current clock-enable pair, the decoded command and
// the all-banks-idle flag, it selects RUN, PDOWN, SREF, RECOVER or
// SUSPEND. It also reports refresh activity and rule-breaking commands.
// Assumes all inputs are synchronous to clk.
module cke_power_ctrl
    import cke_pwr_pkg::*;
#(
    parameter int RC_CYCLES = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cke_i,
    input  logic       cs_n_i,
    input  logic       ras_n_i,
    input  logic       cas_n_i,
    input  logic       we_n_i,
    input  logic       banks_idle_i,
    output logic [2:0] pstate_o,
    output logic       refresh_busy_o,
    output logic       illegal_o
);

    logic       cke_prev, cke_fall, cke_rise, cke_hold_low;
    cmd_class_t cls;
    logic       quiet_cmd;
    logic       rc_load, rc_done;
    pstate_e    state_q, state_d;
    logic       ill_d, ill_q;

    cke_edge_sampler u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .cke_i      (cke_i),
        .cke_prev_o (cke_prev),
        .fall_o     (cke_fall),
        .rise_o     (cke_rise),
        .hold_low_o (cke_hold_low)
    );

    cke_cmd_classifier u_cls (
        .cs_n_i  (cs_n_i),
        .ras_n_i (ras_n_i),
        .cas_n_i (cas_n_i),
        .we_n_i  (we_n_i),
        .cls_o   (cls)
    );

    cke_sr_recovery_timer #(.RC_CYCLES(RC_CYCLES)) u_rc (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (rc_load),
        .en_i   (state_q == PS_RECOVER),
        .done_o (rc_done)
    );

    assign quiet_cmd = cls.desel | cls.nop;

    // Next-state and illegal-command decision for each power state.
    always_comb begin
        state_d = state_q;
        ill_d   = 1'b0;
        rc_load = 1'b0;
        unique case (state_q)
            PS_RUN: begin
                if (cke_fall) begin
                    if (!banks_idle_i) begin
                        state_d = PS_SUSPEND;
                    end else if (cls.refresh) begin
                        state_d = PS_SREF;
                    end else if (quiet_cmd) begin
                        state_d = PS_PDOWN;
                    end else begin
                        state_d = PS_SUSPEND;
                        ill_d   = 1'b1;
                    end
                end
            end
            PS_PDOWN: begin
                if (cke_rise) state_d = PS_RUN;
            end
            PS_SREF: begin
                if (cke_rise) begin
                    if (quiet_cmd) begin
                        state_d = PS_RECOVER;
                        rc_load = 1'b1;
                    end else begin
                        ill_d = 1'b1;
                    end
                end
            end
            PS_RECOVER: begin
                if (!quiet_cmd) ill_d = 1'b1;
                if (rc_done)    state_d = PS_RUN;
            end
            PS_SUSPEND: begin
                if (cke_i) state_d = PS_RUN;
            end
            default: state_d = PS_RUN;
        endcase
    end

    // Register the state and the illegal pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PS_RUN;
            ill_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            ill_q   <= ill_d;
        end
    end

    // Drive the outputs from registered state.
    always_comb begin
        pstate_o       = state_q;
        refresh_busy_o = (state_q == PS_SREF) || (state_q == PS_RECOVER);
        illegal_o      = ill_q;
    end

    // R2
    sref_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && state_q == PS_SREF && $past(state_q) == PS_RUN)
        |-> ($past(banks_idle_i) && !$past(cke_i) && $past(cke_prev)));

    // R6
    pdown_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(state_q) == PS_PDOWN && state_q != PS_PDOWN)
        |-> (state_q == PS_RUN && $past(cke_i)));

    // R7
    sref_leave_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(state_q) == PS_SREF && state_q != PS_SREF)
        |-> (state_q == PS_RECOVER && $past(cke_hold_low) == 1'b0));

    // R7
    recover_leave_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(state_q) == PS_RECOVER && state_q != PS_RECOVER)
        |-> (state_q == PS_RUN && $past(rc_done)));

    // R4
    no_busy_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(state_q) == PS_RUN && !$past(banks_idle_i))
        |-> (state_q == PS_RUN || state_q == PS_SUSPEND));

endmodule

// File: tb/cke_power_ctrl_tb.sv
`timescale 1ns/1ps
module cke_power_ctrl_tb_top;

    localparam int RC = 4;

    // Command pin patterns {cs, ras, cas, we}.
    localparam logic [3:0] NOP = 4'b0111;
    localparam logic [3:0] DSL = 4'b1111;
    localparam logic [3:0] REF = 4'b0001;
    localparam logic [3:0] ACT = 4'b0011;
    localparam logic [3:0] RDC = 4'b0101;

    // Vector: [15:12] req, [11] cke, [10:7] cmd, [6] idle,
    //         [5:3] state, [2] busy, [1] illegal, [0] spare.
    localparam int NV = 26;
    localparam logic [15:0] VEC [NV] = '{
        {4'd10, 1'b1, NOP, 1'b1, 3'd0, 1'b0, 1'b0, 1'b0}, // R10 steady run
        {4'd3,  1'b0, NOP, 1'b1, 3'd1, 1'b0, 1'b0, 1'b0}, // R3 nop entry
        {4'd6,  1'b0, NOP, 1'b1, 3'd1, 1'b0, 1'b0, 1'b0}, // R6 hold
        {4'd6,  1'b1, DSL, 1'b1, 3'd0, 1'b0, 1'b0, 1'b0}, // R6 exit
        {4'd6,  1'b1, NOP, 1'b1, 3'd0, 1'b0, 1'b0, 1'b0}, // R6
        {4'd3,  1'b0, DSL, 1'b1, 3'd1, 1'b0, 1'b0, 1'b0}, // R3 deselect entry
        {4'd6,  1'b1, NOP, 1'b1, 3'd0, 1'b0, 1'b0, 1'b0}, // R6
        {4'd6,  1'b1, NOP, 1'b1, 3'd0, 1'b0, 1'b0, 1'b0}, // R6
        {4'd2,  1'b0, REF, 1'b1, 3'd2, 1'b1, 1'b0, 1'b0}, // R2 entry
        {4'd7,  1'b0, NOP, 1'b1, 3'd2, 1'b1, 1'b0, 1'b0}, // R7 hold
        {4'd8,  1'b1, ACT, 1'b1, 3'd2, 1'b1, 1'b1, 1'b0}, // R8 bad exit
        {4'd8,  1'b0, NOP, 1'b1, 3'd2, 1'b1, 1'b0, 1'b0}, // R8 pulse gone
        {4'd7,  1'b1, NOP, 1'b1, 3'd3, 1'b1, 1'b0, 1'b0}, // R7 exit
        {4'd9,  1'b1, RDC, 1'b1, 3'd3, 1'b1, 1'b1, 1'b0}, // R9 cmd in recovery
        {4'd9,  1'b1, NOP, 1'b1, 3'd3, 1'b1, 1'b0, 1'b0}, // R9
        {4'd7,  1'b1, NOP, 1'b1, 3'd3, 1'b1, 1'b0, 1'b0}, // R7 last cycle
        {4'd7,  1'b1, NOP, 1'b1, 3'd0, 1'b0, 1'b0, 1'b0}, // R7 back to run
        {4'd4,  1'b0, NOP, 1'b0, 3'd4, 1'b0, 1'b0, 1'b0}, // R4 suspend
        {4'd10, 1'b0, ACT, 1'b0, 3'd4, 1'b0, 1'b0, 1'b0}, // R10 hold
        {4'd10, 1'b1, NOP, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0}, // R10 exit
        {4'd5,  1'b0, ACT, 1'b1, 3'd4, 1'b0, 1'b1, 1'b0}, // R5 illegal entry
        {4'd10, 1'b1, NOP, 1'b1, 3'd0, 1'b0, 1'b0, 1'b0}, // R10
        {4'd4,  1'b0, REF, 1'b0, 3'd4, 1'b0, 1'b0, 1'b0}, // R4 refresh ignored
        {4'd10, 1'b1, NOP, 1'b1, 3'd0, 1'b0, 1'b0, 1'b0}, // R10
        {4'd4,  1'b0, DSL, 1'b0, 3'd4, 1'b0, 1'b0, 1'b0}, // R4 deselect ignored
        {4'd10, 1'b1, NOP, 1'b1, 3'd0, 1'b0, 1'b0, 1'b0}  // R10
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cke = 1'b1;
    logic [3:0] cmd = NOP;
    logic       idle = 1'b1;
    logic [2:0] pstate;
    logic       busy, ill;
    int         n_chk = 0;
    int         n_fail = 0;
    bit         finished = 1'b0;

    always #2.5 clk = ~clk;

    cke_power_ctrl #(.RC_CYCLES(RC)) dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .cke_i          (cke),
        .cs_n_i         (cmd[3]),
        .ras_n_i        (cmd[2]),
        .cas_n_i        (cmd[1]),
        .we_n_i         (cmd[0]),
        .banks_idle_i   (idle),
        .pstate_o       (pstate),
        .refresh_busy_o (busy),
        .illegal_o      (ill)
    );

    task automatic check(input string req, input logic [2:0] es,
                         input logic eb, input logic ei);
        n_chk++;
        if (pstate !== es || busy !== eb || ill !== ei) begin
            n_fail++;
            $display("FAIL %s: state/busy/illegal got %0d/%0b/%0b expected %0d/%0b/%0b",
                     req, pstate, busy, ill, es, eb, ei);
        end
    endtask

    // Drive inputs at the falling edge, then sample just after the rising edge.
    task automatic step(input logic c, input logic [3:0] k, input logic id);
        @(negedge clk);
        cke = c; cmd = k; idle = id;
        @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run got hung expected completion");
        finish_run();
    end

    initial begin
        // R1 reset state
        repeat (3) @(posedge clk);
        #1;
        check("R1", 3'd0, 1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check("R1", 3'd0, 1'b0, 1'b0);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            logic [15:0] v;
            string       tag;
            v = VEC[i];
            step(v[11], v[10:7], v[6]);
            tag = $sformatf("R%0d vec %0d", v[15:12], i);
            check(tag, v[5:3], v[2], v[1]);
        end

        // R7 deselect exit and recovery length counted at the ports
        step(1'b0, REF, 1'b1);
        check("R2", 3'd2, 1'b1, 1'b0);
        step(1'b0, REF, 1'b1);
        check("R7", 3'd2, 1'b1, 1'b0);
        step(1'b1, DSL, 1'b1);
        check("R7", 3'd3, 1'b1, 1'b0);
        begin
            int rec_len;
            rec_len = 1;
            for (int k = 0; k < 20 && pstate == 3'd3; k++) begin
                step(1'b1, DSL, 1'b1);
                if (pstate == 3'd3) rec_len++;
            end
            n_chk++;
            if (rec_len != RC) begin
                n_fail++;
                $display("FAIL R7: recovery length got %0d expected %0d", rec_len, RC);
            end
            check("R7", 3'd0, 1'b0, 1'b0);
        end

        // R1 reset in the middle of self-refresh
        step(1'b0, REF, 1'b1);
        check("R2", 3'd2, 1'b1, 1'b0);
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check("R1", 3'd0, 1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        cke = 1'b1; cmd = NOP;
        @(posedge clk);
        #1;
        check("R1", 3'd0, 1'b0, 1'b0);

        finish_run();
    end

endmodule